// File: doc/BRIEF.md
# I2C Target with Processor Register Window

This block is an I2C target (slave) with 7-bit addressing. It turns the two-wire serial bus into a small register window that a processor can read and write. It works at standard and fast bus rates because both bus lines are oversampled by the system clock. It answers to a programmable own address. It can also answer to the fixed display segment-pointer address, which is 0x30 in 7 bits and appears on the wire as 60h for writes and 61h for reads. Configuration turns each of these two matches on or off.

The processor has four registers, chosen by `cpu_sel`:

- DATA (0): a read returns the last received byte, and a write loads the byte to send.
- STATUS (1): a read returns the flags and clears the sticky ones.
- OWN (2): bits [6:0] hold the own address, and bit 7 enables the own-address match.
- CTRL (3): bit 0 enables the segment-address match, bit 1 enables the interrupt, and bit 2 lets the block acknowledge received data bytes.

The STATUS bits are:

| Bit | Meaning |
|-----|---------|
| 0 | bus busy |
| 1 | START seen |
| 2 | address matched |
| 3 | byte done |
| 4 | transmit direction |
| 5 | STOP seen |
| 6 | misplaced condition |
| 7 | master sent a NACK |

The state machine has these states: IDLE, ADDR, ADDR_ACK, RECV, RECV_ACK, SEND, SEND_ACK and WAIT_STOP. Its transitions are:

- **START and STOP:** from any state, a START goes to ADDR and a STOP goes to IDLE.
- **Address byte:** ADDR goes to ADDR_ACK on a match, or to WAIT_STOP on a miss. This happens at the falling SCL edge after the eighth bit.
- **After the address acknowledge:** ADDR_ACK goes to SEND when R/W is 1, or to RECV when it is 0, at the falling edge that ends the acknowledge clock.
- **Receiving:** RECV goes to RECV_ACK if acknowledge is enabled, or to WAIT_STOP if not, after eight bits. RECV_ACK returns to RECV.
- **Sending:** SEND goes to SEND_ACK after eight bits. SEND_ACK returns to SEND, with the next byte reloaded, on an ACK. It goes to WAIT_STOP on a NACK.

Top module: `i2cs_regslave`

## Requirements
- R1: After reset, STATUS reads 0x00, `irq` is low and `sda_drive_low` is low.
- R2: A START sets STATUS bit 0 (busy) and bit 1 (START seen). A STOP clears bit 0 and sets bit 5 (STOP seen). Bits 1, 2, 5, 6 and 7 clear when STATUS is read.
- R3: With OWN bit 7 set, an address byte whose upper seven bits equal OWN[6:0] is acknowledged, and STATUS bit 2 is set.
- R4: With CTRL bit 0 set, the 7-bit address 0x30 (60h or 61h on the wire) is acknowledged and sets STATUS bit 2. With CTRL bit 0 clear, that address is not acknowledged.
- R5: An address that does not match gets no acknowledge. The block then ignores the bus, acknowledging nothing and setting no byte-done flag, until the next START or STOP.
- R6: In a write transfer, each received byte appears in DATA and sets STATUS bit 3. The byte is acknowledged when CTRL bit 2 is set, and gets a NACK when it is clear.
- R7: STATUS bit 3 stays set until DATA is read or written. Reading STATUS does not clear it.
- R8: STATUS bit 4 takes the R/W bit of the matched address byte (1 means the block transmits). A STOP clears it.
- R9: In a read transfer, the block sends the byte last written to DATA, MSB first. It reloads DATA after each master ACK. The master's acknowledge bit is stored in STATUS bit 7 (1 = NACK). After a NACK, SDA is released.
- R10: A START or STOP that arrives after two or more bits of a byte have been clocked in sets STATUS bit 6.
- R11: `irq` is high exactly when CTRL bit 1 is set and any of STATUS bits 2, 3, 5 or 6 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_drive_low | output | 1 | Pull the SDA line low when high |
| cpu_sel | input | 2 | Register select: 0 DATA, 1 STATUS, 2 OWN, 3 CTRL |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (side effects) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the STOP that legitimately follows an acknowledge. The STOP arrives one SCL rise into the next byte, so a design that counted that rise as a byte fragment would raise a false misplaced-condition error. A STOP sent after three data bits must still raise that error.

Two other corner cases are the segment address with its enable cleared, and a data byte received with acknowledge disabled. A design that ignored either enable would pull SDA low where the master expects a NACK.

In a read transfer, the bench checks the reload after a master ACK and the release after a NACK. A design that reloaded too early would send a stale byte, and one that kept driving after the NACK would block the STOP. Reading STATUS must leave the byte-done flag standing; a design that cleared it there would lose the interrupt.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RECV,
        ST_RECV_ACK, ST_SEND, ST_SEND_ACK, ST_WAIT_STOP
    } slv_state_t;

    localparam logic [1:0] SEL_DATA   = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;
    localparam logic [1:0] SEL_OWN    = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;
endpackage

// File: rtl/i2cs_line_sync.sv
`timescale 1ns/1ps
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop,
    output logic sda_level
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_q, sda_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= synced[1];
            sda_q <= synced[0];
        end
    end

    assign sda_level = synced[0];
    assign scl_rise  = synced[1] & ~scl_q;
    assign scl_fall  = ~synced[1] & scl_q;
    assign bus_start = synced[1] & scl_q & sda_q & ~synced[0];
    assign bus_stop  = synced[1] & scl_q & ~sda_q & synced[0];
endmodule

// File: rtl/i2cs_fsm.sv
`timescale 1ns/1ps
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SEG_ADDR = 7'h30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       sda_level,
    input  logic [6:0] own_addr,
    input  logic       own_en,
    input  logic       seg_en,
    input  logic       ack_en,
    input  logic [7:0] tx_byte,
    output logic       sda_low,
    output logic       ev_match,
    output logic       rw_bit,
    output logic       ev_rx,
    output logic [7:0] rx_byte,
    output logic       ev_tx,
    output logic       nack_bit,
    output logic       ev_misplaced
);
    slv_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       shreg, txsh;
    logic             hit, misplaced;

    assign hit = (own_en && shreg[7:1] == own_addr) || (seg_en && shreg[7:1] == SEG_ADDR);
    assign misplaced = (bus_start || bus_stop) && (cnt >= CNT_W'(2)) &&
                       (state == ST_ADDR || state == ST_RECV || state == ST_SEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;  cnt <= '0;  shreg <= '0;  txsh <= '0;
            rw_bit <= 1'b0;    nack_bit <= 1'b0;  rx_byte <= '0;
            ev_match <= 1'b0;  ev_rx <= 1'b0;  ev_tx <= 1'b0;  ev_misplaced <= 1'b0;
        end else begin
            ev_match <= 1'b0;  ev_rx <= 1'b0;  ev_tx <= 1'b0;  ev_misplaced <= 1'b0;
            if (bus_stop) begin
                state <= ST_IDLE;  cnt <= '0;  ev_misplaced <= misplaced;
            end else if (bus_start) begin
                state <= ST_ADDR;  cnt <= '0;  ev_misplaced <= misplaced;
            end else begin
                unique case (state)
                    ST_IDLE, ST_WAIT_STOP: ;
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_level};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_W'(BYTE_BITS)) begin
                            cnt <= '0;
                            if (hit) begin
                                state    <= ST_ADDR_ACK;
                                ev_match <= 1'b1;
                                rw_bit   <= shreg[0];
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw_bit) begin
                                state <= ST_SEND;
                                txsh  <= tx_byte;
                            end else begin
                                state <= ST_RECV;
                            end
                        end
                    end
                    ST_RECV: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_level};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_W'(BYTE_BITS)) begin
                            cnt     <= '0;
                            ev_rx   <= 1'b1;
                            rx_byte <= shreg;
                            state   <= ack_en ? ST_RECV_ACK : ST_WAIT_STOP;
                        end
                    end
                    ST_RECV_ACK: if (scl_fall) state <= ST_RECV;
                    ST_SEND: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == CNT_W'(BYTE_BITS)) begin
                                cnt   <= '0;
                                state <= ST_SEND_ACK;
                            end else begin
                                txsh <= {txsh[6:0], 1'b0};
                            end
                        end
                    end
                    ST_SEND_ACK: begin
                        if (scl_rise) begin
                            nack_bit <= sda_level;
                            ev_tx    <= 1'b1;
                        end else if (scl_fall) begin
                            if (nack_bit) begin
                                state <= ST_WAIT_STOP;
                            end else begin
                                state <= ST_SEND;
                                txsh  <= tx_byte;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_RECV_ACK: sda_low = 1'b1;
            ST_SEND:                  sda_low = ~txsh[7];
            default:                  sda_low = 1'b0;
        endcase
    end

    a_r3_match_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ev_match |-> (own_en || seg_en));
    a_r10_error_ends_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ev_misplaced |-> (state == ST_IDLE || state == ST_ADDR));
    a_r9_release_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND_ACK && scl_fall && nack_bit && !bus_start && !bus_stop) |=> !sda_low);
endmodule

// File: rtl/i2cs_regs.sv
`timescale 1ns/1ps
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cpu_sel,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       irq,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       ev_match,
    input  logic       rw_bit,
    input  logic       ev_rx,
    input  logic [7:0] rx_byte,
    input  logic       ev_tx,
    input  logic       nack_bit,
    input  logic       ev_misplaced,
    output logic [6:0] own_addr,
    output logic       own_en,
    output logic       seg_en,
    output logic       ack_en,
    output logic [7:0] tx_byte,
    output logic       busy
);
    logic       f_start, f_match, f_done, f_tx, f_stop, f_err, f_nack, irq_en;
    logic [7:0] rx_q, status;
    logic       status_rd, data_acc;

    assign status_rd = cpu_rd && cpu_sel == SEL_STATUS;
    assign data_acc  = (cpu_rd || cpu_wr) && cpu_sel == SEL_DATA;
    assign status    = {f_nack, f_err, f_stop, f_tx, f_done, f_match, f_start, busy};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;  f_start <= 1'b0;  f_match <= 1'b0;  f_done <= 1'b0;
            f_tx <= 1'b0;  f_stop <= 1'b0;   f_err <= 1'b0;    f_nack <= 1'b0;
            rx_q <= '0;    tx_byte <= '0;    own_addr <= '0;   own_en <= 1'b0;
            seg_en <= 1'b0; irq_en <= 1'b0;  ack_en <= 1'b0;
        end else begin
            if (bus_start)     busy <= 1'b1;
            else if (bus_stop) busy <= 1'b0;
            f_start <= bus_start    | (f_start & ~status_rd);
            f_stop  <= bus_stop     | (f_stop  & ~status_rd);
            f_match <= ev_match     | (f_match & ~status_rd);
            f_err   <= ev_misplaced | (f_err   & ~status_rd);
            f_done  <= ev_rx | ev_tx | (f_done & ~data_acc);
            if (ev_tx)          f_nack <= nack_bit;
            else if (status_rd) f_nack <= 1'b0;
            if (ev_match)      f_tx <= rw_bit;
            else if (bus_stop) f_tx <= 1'b0;
            if (ev_rx) rx_q <= rx_byte;
            if (cpu_wr) begin
                unique case (cpu_sel)
                    SEL_DATA:   tx_byte <= cpu_wdata;
                    SEL_STATUS: ;
                    SEL_OWN:    {own_en, own_addr} <= cpu_wdata;
                    SEL_CTRL:   {ack_en, irq_en, seg_en} <= cpu_wdata[2:0];
                endcase
            end
        end
    end

    always_comb begin
        unique case (cpu_sel)
            SEL_DATA:   cpu_rdata = rx_q;
            SEL_STATUS: cpu_rdata = status;
            SEL_OWN:    cpu_rdata = {own_en, own_addr};
            SEL_CTRL:   cpu_rdata = {5'b0, ack_en, irq_en, seg_en};
        endcase
    end

    assign irq = irq_en & (f_match | f_done | f_stop | f_err);

    a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> busy);
    a_r2_free_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !busy);
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && !data_acc) |=> f_done);
    a_r8_dir_from_match: assert property (@(posedge clk) disable iff (!rst_n)
        ev_match |=> (f_tx == $past(rw_bit)));
endmodule

// File: rtl/i2cs_regslave.sv
`timescale 1ns/1ps
module i2cs_regslave
    import i2cs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] SEG_ADDR    = 7'h30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low,
    input  logic [1:0] cpu_sel,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       irq
);
    logic       scl_rise, scl_fall, bus_start, bus_stop, sda_level;
    logic       ev_match, rw_bit, ev_rx, ev_tx, nack_bit, ev_misplaced;
    logic [7:0] rx_byte, tx_byte;
    logic [6:0] own_addr;
    logic       own_en, seg_en, ack_en, busy;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .sda_level(sda_level)
    );

    i2cs_fsm #(.SEG_ADDR(SEG_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .sda_level(sda_level),
        .own_addr(own_addr), .own_en(own_en), .seg_en(seg_en), .ack_en(ack_en),
        .tx_byte(tx_byte), .sda_low(sda_drive_low), .ev_match(ev_match),
        .rw_bit(rw_bit), .ev_rx(ev_rx), .rx_byte(rx_byte), .ev_tx(ev_tx),
        .nack_bit(nack_bit), .ev_misplaced(ev_misplaced)
    );

    i2cs_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .bus_start(bus_start), .bus_stop(bus_stop), .ev_match(ev_match),
        .rw_bit(rw_bit), .ev_rx(ev_rx), .rx_byte(rx_byte), .ev_tx(ev_tx),
        .nack_bit(nack_bit), .ev_misplaced(ev_misplaced), .own_addr(own_addr),
        .own_en(own_en), .seg_en(seg_en), .ack_en(ack_en), .tx_byte(tx_byte),
        .busy(busy)
    );

    a_r1_drive_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> busy);
endmodule

// File: tb/test_i2cs_regslave.sv
`timescale 1ns/1ps
module test_i2cs_regslave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_drive_low, irq;
    logic [1:0] cpu_sel = 2'd0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00, cpu_rdata;
    logic       sda_line;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    assign sda_line = sda_m & ~sda_drive_low;

    always #10 clk = ~clk;

    i2cs_regslave i_i2cs_regslave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_drive_low(sda_drive_low), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cpu_sel = sel; cpu_wdata = val; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        cpu_sel = sel; cpu_rd = 1'b1;
        #1 val = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic chk_st(input string tag, input logic [7:0] mask, input logic [7:0] exp);
        logic [7:0] v;
        cpu_read(2'd1, v);
        check(tag, v & mask, exp);
    endtask

    // scoreboard driver side: expected received byte
    task automatic sb_push(input string tag, input logic [7:0] val);
        exp_q.push_back(val);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor side: DATA read compared against the queue head
    task automatic sb_pop_data();
        logic [7:0] v;
        cpu_read(2'd0, v);
        if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %02h expected none", v);
        end else begin
            check(tag_q.pop_front(), v, exp_q.pop_front());
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(1);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_q(1);
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        b = sda_line; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic write_byte(input logic [7:0] val, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(val[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic read_byte(output logic [7:0] val, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            val[i] = b;
        end
        send_bit(~give_ack);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk_st("R1 status", 8'hFF, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 sda", {7'b0, sda_drive_low}, 8'h00);

        cpu_write(2'd2, 8'hC2);   // own 0x42 enabled
        cpu_write(2'd3, 8'h05);   // seg match + ack enable

        // R2 R3 R6 R7 R8: write transfer to own address
        i2c_start();
        chk_st("R2 start", 8'hFF, 8'h03);
        chk_st("R2 cleared", 8'hFF, 8'h01);
        write_byte(8'h84, ack);
        check("R3 ack", {7'b0, ack}, 8'h01);
        chk_st("R3 R8 match wr", 8'hFF, 8'h05);
        sb_push("R6 data 5A", 8'h5A);
        write_byte(8'h5A, ack);
        check("R6 ack", {7'b0, ack}, 8'h01);
        chk_st("R6 done", 8'hFF, 8'h09);
        chk_st("R7 done holds", 8'hFF, 8'h09);
        sb_pop_data();
        chk_st("R7 done cleared", 8'hFF, 8'h01);
        sb_push("R6 data A5", 8'hA5);
        write_byte(8'hA5, ack);
        check("R6 ack2", {7'b0, ack}, 8'h01);
        sb_pop_data();
        i2c_stop();
        chk_st("R2 stop R10 no error", 8'hFF, 8'h20);
        chk_st("R2 stop cleared", 8'hFF, 8'h00);

        // R4 segment address
        i2c_start();
        write_byte(8'h60, ack);
        check("R4 seg ack", {7'b0, ack}, 8'h01);
        chk_st("R4 seg match", 8'h04, 8'h04);
        sb_push("R4 seg data", 8'h01);
        write_byte(8'h01, ack);
        sb_pop_data();
        i2c_stop();
        chk_st("R4 clear", 8'h00, 8'h00);
        cpu_write(2'd3, 8'h04);
        i2c_start();
        write_byte(8'h60, ack);
        check("R4 seg disabled nack", {7'b0, ack}, 8'h00);
        chk_st("R4 no match", 8'h04, 8'h00);
        i2c_stop();
        chk_st("R4 clear2", 8'h00, 8'h00);

        // R5 address miss
        i2c_start();
        write_byte(8'h22, ack);
        check("R5 addr nack", {7'b0, ack}, 8'h00);
        write_byte(8'h33, ack);
        check("R5 data ignored", {7'b0, ack}, 8'h00);
        chk_st("R5 no done no match", 8'h0C, 8'h00);
        i2c_stop();
        chk_st("R5 clear", 8'h00, 8'h00);

        // R6 acknowledge disabled
        cpu_write(2'd3, 8'h01);
        i2c_start();
        write_byte(8'h84, ack);
        check("R6 addr ack", {7'b0, ack}, 8'h01);
        sb_push("R6 nacked data", 8'h11);
        write_byte(8'h11, ack);
        check("R6 data nack", {7'b0, ack}, 8'h00);
        chk_st("R6 done on nack", 8'h08, 8'h08);
        sb_pop_data();
        i2c_stop();
        chk_st("R6 clear", 8'h00, 8'h00);

        // R8 R9 read transfer
        cpu_write(2'd3, 8'h05);
        cpu_write(2'd0, 8'hC3);
        i2c_start();
        write_byte(8'h85, ack);
        check("R9 addr ack", {7'b0, ack}, 8'h01);
        chk_st("R8 tx dir", 8'hFF, 8'h17);
        cpu_write(2'd0, 8'h3C);
        read_byte(v, 1'b1);
        check("R9 first byte", v, 8'hC3);
        chk_st("R9 ack seen", 8'hFF, 8'h19);
        read_byte(v, 1'b0);
        check("R9 reloaded byte", v, 8'h3C);
        chk_st("R9 nack seen", 8'hFF, 8'h99);
        check("R9 released", {7'b0, sda_drive_low}, 8'h00);
        i2c_stop();
        chk_st("R8 dir cleared", 8'h11, 8'h00);
        cpu_read(2'd0, v);

        // R10 misplaced STOP
        i2c_start();
        write_byte(8'h84, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        i2c_stop();
        chk_st("R10 error", 8'h40, 8'h40);
        chk_st("R10 cleared", 8'h40, 8'h00);

        // R11 interrupt
        cpu_read(2'd0, v);
        cpu_write(2'd3, 8'h07);
        check("R11 idle irq", {7'b0, irq}, 8'h00);
        i2c_start();
        write_byte(8'h84, ack);
        check("R11 irq on match", {7'b0, irq}, 8'h01);
        chk_st("R11 clear match", 8'h00, 8'h00);
        check("R11 irq low", {7'b0, irq}, 8'h00);
        sb_push("R11 data", 8'h77);
        write_byte(8'h77, ack);
        check("R11 irq on byte", {7'b0, irq}, 8'h01);
        sb_pop_data();
        check("R11 irq after data", {7'b0, irq}, 8'h00);
        i2c_stop();
        check("R11 irq on stop", {7'b0, irq}, 8'h01);
        chk_st("R11 clear stop", 8'h00, 8'h00);
        check("R11 irq final", {7'b0, irq}, 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule